// File: doc/BRIEF.md
# Video DAC Output Router

This block sits between the encoder's sample streams and the four video digital-to-analog converters. It runs at the doubled pixel rate of 27 MHz. Its inputs are an encoded luma code, a modulated chroma code, a red/green/blue triple, and the matching Cr/Y/Cb component triple. It adds luma and chroma to form a composite value, clamps that sum, and scales it to fifteen sixteenths. It then places the composite, luma, chroma and colour values onto four 10-bit DAC buses.

Two mode bits choose the output set.
- By default the buses carry composite plus red, green and blue.
- A component bit replaces red, green and blue with Cr, Y and Cb.
- A separate-video bit carries luma, chroma and two copies of composite.

Two power-down bits each force one pair of buses to code zero. Every path, including the control bits, has the same three-edge latency. A mode change therefore applies exactly to the samples captured with it.

Top module: `vdac_route`

## Requirements
- R1: While `rst_n` is low, all four DAC buses read 0, and a low `rst_n` clears them without waiting for a clock edge. After release, they stay 0 until the first captured sample has passed through the pipeline.
- R2: The composite value is first formed as `y_i + c_i - 512`, where chroma is offset binary with 512 as zero. The result is clamped to the range 0 to 1023, so any sum below 0 gives composite 0 and any sum above 1023 gives composite 959.
- R3: The clamped composite value s is scaled as `(s*15 + 8) >> 4`, so composite never exceeds 959.
- R4: With `svid_en_i` and `dmx_off_i` both low, the buses carry the following. The 9-bit codes are left-justified with bit 0 cleared.

  | Bus | Content |
  |---|---|
  | `dac_cvbs_o` | composite |
  | `dac_red_o` | `red_i*2` |
  | `dac_grn_o` | `grn_i*2` |
  | `dac_blu_o` | `blu_i*2` |

- R5: With `dmx_off_i` high and `svid_en_i` low, the three colour buses carry `cr_i*2`, `yl_i*2` and `cb_i*2`. `dac_cvbs_o` still carries composite.
- R6: With `svid_en_i` high, `dmx_off_i` has no effect and the buses carry the following.

  | Bus | Content |
  |---|---|
  | `dac_cvbs_o` | `y_i` |
  | `dac_red_o` | `c_i` |
  | `dac_grn_o` | composite |
  | `dac_blu_o` | composite |

- R7: `pd_lo_i` forces `dac_cvbs_o` and `dac_red_o` to 0. `pd_hi_i` forces `dac_grn_o` and `dac_blu_o` to 0. Each bit leaves the other pair untouched.
- R8: Data, mode bits and power-down bits all reach the buses after the same number of edges. A value present before rising edge E is on the buses after edge E+2 and not after edge E+1. Back-to-back samples with differing modes are each routed by their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| y_i | input | 10 | Encoded luma code |
| c_i | input | 10 | Modulated chroma, offset binary around 512 |
| red_i | input | 9 | Red component |
| grn_i | input | 9 | Green component |
| blu_i | input | 9 | Blue component |
| cr_i | input | 9 | Cr component for the component set |
| yl_i | input | 9 | Luma component for the component set |
| cb_i | input | 9 | Cb component for the component set |
| svid_en_i | input | 1 | Selects the separate-video-plus-twin-composite set |
| dmx_off_i | input | 1 | Selects Cr/Y/Cb in place of red/green/blue |
| pd_lo_i | input | 1 | Forces the composite and red buses to 0 |
| pd_hi_i | input | 1 | Forces the green and blue buses to 0 |
| dac_cvbs_o | output | 10 | Bus to DAC 1 |
| dac_red_o | output | 10 | Bus to DAC 2 |
| dac_grn_o | output | 10 | Bus to DAC 3 |
| dac_blu_o | output | 10 | Bus to DAC 4 |

## Verification
Every result is registered three times: at input capture, at the composite stage, and at the routed output. A sample driven on a falling edge is therefore due after the third following rising edge, and the bench samples it on the falling edge that comes next. The vector table is driven one row per cycle, and each row is compared three falling edges after it was applied. This catches a latency mismatch between any data path and the mode or power-down bits. A directed test also confirms that the old value is still present after only two edges.

// File: rtl/vdac_pkg.sv
package vdac_pkg;

  localparam int VD_YW = 10;
  localparam int VD_CW = 9;

  typedef enum logic [1:0] {
    RT_RGB  = 2'd0,
    RT_CMP  = 2'd1,
    RT_SVID = 2'd2
  } vd_route_e;

  // separate-video selection outranks the component selection
  function automatic vd_route_e vd_pick(input logic svid, input logic dmx_off);
    if (svid)         return RT_SVID;
    else if (dmx_off) return RT_CMP;
    else              return RT_RGB;
  endfunction

endpackage

// File: rtl/vdac_pipe.sv
module vdac_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= stg[k-1];
      end
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/vdac_cvbs.sv
module vdac_cvbs #(
  parameter int YW        = 10,
  parameter int SCALE_NUM = 15,
  parameter int SCALE_SH  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [YW-1:0] y,
  input  logic [YW-1:0] c,
  output logic [YW-1:0] cvbs_q,
  output logic          clip_lo,
  output logic          clip_hi
);

  localparam int SW     = YW + 2;
  localparam int PW     = YW + SCALE_SH;
  localparam int MAXV   = (1 << YW) - 1;
  localparam int MID    = 1 << (YW - 1);
  localparam int RND    = 1 << (SCALE_SH - 1);
  localparam int CV_MAX = (MAXV * SCALE_NUM + RND) >> SCALE_SH;
  localparam logic signed [SW-1:0] S_MAX = SW'(MAXV);

  // clamp the offset-corrected sum, then scale with rounding
  function automatic logic [YW-1:0] comp_scale(input logic [YW-1:0] yv,
                                               input logic [YW-1:0] cv);
    logic signed [SW-1:0] s;
    logic [YW-1:0]        cl;
    logic [PW-1:0]        p;
    s = SW'(yv) + SW'(cv) - SW'(MID);
    if (s[SW-1])       cl = '0;
    else if (s > S_MAX) cl = YW'(MAXV);
    else               cl = s[YW-1:0];
    p = PW'(cl) * PW'(SCALE_NUM) + PW'(RND);
    return p[PW-1:SCALE_SH];
  endfunction

  logic signed [SW-1:0] sum_w;
  assign sum_w   = SW'(y) + SW'(c) - SW'(MID);
  assign clip_lo = sum_w[SW-1];
  assign clip_hi = !sum_w[SW-1] && (sum_w > S_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cvbs_q <= '0;
    else        cvbs_q <= comp_scale(y, c);
  end

  // R2: a negative sum yields zero composite
  p_clip_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clip_lo |=> (cvbs_q == '0));
  // R2: an overflowing sum yields the scaled full-scale value
  p_clip_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clip_hi |=> (cvbs_q == YW'(CV_MAX)));
  // R3: scaled composite stays within fifteen sixteenths of full scale
  p_cvbs_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cvbs_q <= YW'(CV_MAX));

endmodule

// File: rtl/vdac_xbar.sv
module vdac_xbar
  import vdac_pkg::*;
#(
  parameter int YW = 10,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vd_route_e     route,
  input  logic          pd_lo,
  input  logic          pd_hi,
  input  logic [YW-1:0] y,
  input  logic [YW-1:0] c,
  input  logic [YW-1:0] cvbs,
  input  logic [CW-1:0] r,
  input  logic [CW-1:0] g,
  input  logic [CW-1:0] b,
  input  logic [CW-1:0] cr,
  input  logic [CW-1:0] yl,
  input  logic [CW-1:0] cb,
  output logic [YW-1:0] dac_cvbs_o,
  output logic [YW-1:0] dac_red_o,
  output logic [YW-1:0] dac_grn_o,
  output logic [YW-1:0] dac_blu_o
);

  localparam int PAD = YW - CW;

  function automatic logic [YW-1:0] widen(input logic [CW-1:0] v);
    return {v, {PAD{1'b0}}};
  endfunction

  logic [YW-1:0] sel0, sel1, sel2, sel3;

  always_comb begin
    unique case (route)
      RT_SVID: begin
        sel0 = y;
        sel1 = c;
        sel2 = cvbs;
        sel3 = cvbs;
      end
      RT_CMP: begin
        sel0 = cvbs;
        sel1 = widen(cr);
        sel2 = widen(yl);
        sel3 = widen(cb);
      end
      default: begin
        sel0 = cvbs;
        sel1 = widen(r);
        sel2 = widen(g);
        sel3 = widen(b);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_cvbs_o <= '0;
      dac_red_o  <= '0;
      dac_grn_o  <= '0;
      dac_blu_o  <= '0;
    end else begin
      dac_cvbs_o <= pd_lo ? '0 : sel0;
      dac_red_o  <= pd_lo ? '0 : sel1;
      dac_grn_o  <= pd_hi ? '0 : sel2;
      dac_blu_o  <= pd_hi ? '0 : sel3;
    end
  end

  // R7: each power-down bit clamps its own pair
  p_pd_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_lo |=> (dac_cvbs_o == '0 && dac_red_o == '0));
  p_pd_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_hi |=> (dac_grn_o == '0 && dac_blu_o == '0));
  // R6: green and blue carry the same composite in separate-video mode
  p_svid_twin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_SVID) |=> (dac_grn_o == dac_blu_o));
  // R4: colour buses carry left-justified 9-bit codes outside separate-video mode
  p_lsb_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (route != RT_SVID) |=> (dac_red_o[PAD-1:0] == '0 &&
                            dac_grn_o[PAD-1:0] == '0 &&
                            dac_blu_o[PAD-1:0] == '0));

endmodule

// File: rtl/vdac_route.sv
module vdac_route
  import vdac_pkg::*;
#(
  parameter int YW = VD_YW,
  parameter int CW = VD_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [YW-1:0] y_i,
  input  logic [YW-1:0] c_i,
  input  logic [CW-1:0] red_i,
  input  logic [CW-1:0] grn_i,
  input  logic [CW-1:0] blu_i,
  input  logic [CW-1:0] cr_i,
  input  logic [CW-1:0] yl_i,
  input  logic [CW-1:0] cb_i,
  input  logic          svid_en_i,
  input  logic          dmx_off_i,
  input  logic          pd_lo_i,
  input  logic          pd_hi_i,
  output logic [YW-1:0] dac_cvbs_o,
  output logic [YW-1:0] dac_red_o,
  output logic [YW-1:0] dac_grn_o,
  output logic [YW-1:0] dac_blu_o
);

  localparam int BW = 2 * YW + 6 * CW + 4;

  // stage 1: capture every input, control bits included
  logic [YW-1:0] y_s1, c_s1;
  logic [CW-1:0] r_s1, g_s1, b_s1, cr_s1, yl_s1, cb_s1;
  logic          svid_s1, dmx_s1, pdl_s1, pdh_s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_s1 <= '0; c_s1 <= '0;
      r_s1 <= '0; g_s1 <= '0; b_s1 <= '0;
      cr_s1 <= '0; yl_s1 <= '0; cb_s1 <= '0;
      svid_s1 <= 1'b0; dmx_s1 <= 1'b0; pdl_s1 <= 1'b0; pdh_s1 <= 1'b0;
    end else begin
      y_s1 <= y_i; c_s1 <= c_i;
      r_s1 <= red_i; g_s1 <= grn_i; b_s1 <= blu_i;
      cr_s1 <= cr_i; yl_s1 <= yl_i; cb_s1 <= cb_i;
      svid_s1 <= svid_en_i; dmx_s1 <= dmx_off_i;
      pdl_s1 <= pd_lo_i; pdh_s1 <= pd_hi_i;
    end
  end

  // stage 2: composite arithmetic alongside a matching delay for the rest
  logic [YW-1:0] cvbs_s2;
  logic          clip_lo_w, clip_hi_w;

  vdac_cvbs #(.YW(YW)) u_cvbs (
    .clk     (clk),
    .rst_n   (rst_n),
    .y       (y_s1),
    .c       (c_s1),
    .cvbs_q  (cvbs_s2),
    .clip_lo (clip_lo_w),
    .clip_hi (clip_hi_w)
  );

  logic [BW-1:0] bus_s1, bus_s2;
  assign bus_s1 = {y_s1, c_s1, r_s1, g_s1, b_s1, cr_s1, yl_s1, cb_s1,
                   svid_s1, dmx_s1, pdl_s1, pdh_s1};

  vdac_pipe #(.W(BW), .DEPTH(1)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_s1),
    .q     (bus_s2)
  );

  logic [YW-1:0] y_s2, c_s2;
  logic [CW-1:0] r_s2, g_s2, b_s2, cr_s2, yl_s2, cb_s2;
  logic          svid_s2, dmx_s2, pdl_s2, pdh_s2;
  assign {y_s2, c_s2, r_s2, g_s2, b_s2, cr_s2, yl_s2, cb_s2,
          svid_s2, dmx_s2, pdl_s2, pdh_s2} = bus_s2;

  vd_route_e route_s2;
  assign route_s2 = vd_pick(svid_s2, dmx_s2);

  // stage 3: routing and power-down into the output registers
  vdac_xbar #(.YW(YW), .CW(CW)) u_xbar (
    .clk        (clk),
    .rst_n      (rst_n),
    .route      (route_s2),
    .pd_lo      (pdl_s2),
    .pd_hi      (pdh_s2),
    .y          (y_s2),
    .c          (c_s2),
    .cvbs       (cvbs_s2),
    .r          (r_s2),
    .g          (g_s2),
    .b          (b_s2),
    .cr         (cr_s2),
    .yl         (yl_s2),
    .cb         (cb_s2),
    .dac_cvbs_o (dac_cvbs_o),
    .dac_red_o  (dac_red_o),
    .dac_grn_o  (dac_grn_o),
    .dac_blu_o  (dac_blu_o)
  );

  // R8: a captured power-down bit reaches the buses two edges after capture
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pdl_s1 |-> ##2 (dac_cvbs_o == '0 && dac_red_o == '0));
  // R8 with R6: a captured separate-video bit shows up two edges after capture
  p_latency_svid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svid_s1 |-> ##2 (dac_grn_o == dac_blu_o));

endmodule

// File: tb/vdac_route_tb.sv
module vdac_route_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] y_i, c_i;
  logic [8:0] red_i, grn_i, blu_i, cr_i, yl_i, cb_i;
  logic       svid_en_i, dmx_off_i, pd_lo_i, pd_hi_i;
  logic [9:0] dac_cvbs_o, dac_red_o, dac_grn_o, dac_blu_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vdac_route u_dut (
    .clk(clk), .rst_n(rst_n),
    .y_i(y_i), .c_i(c_i),
    .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
    .cr_i(cr_i), .yl_i(yl_i), .cb_i(cb_i),
    .svid_en_i(svid_en_i), .dmx_off_i(dmx_off_i),
    .pd_lo_i(pd_lo_i), .pd_hi_i(pd_hi_i),
    .dac_cvbs_o(dac_cvbs_o), .dac_red_o(dac_red_o),
    .dac_grn_o(dac_grn_o), .dac_blu_o(dac_blu_o)
  );

  // row: y c r g b cr yl cb | svid dmx pdl pdh | expected composite
  localparam int N = 9;
  localparam logic [87:0] TBL [N] = '{
    {10'd512, 10'd512, 9'd100, 9'd200, 9'd300, 9'd11,  9'd22,  9'd33,  4'b0000, 10'd480},
    {10'd1000,10'd900, 9'd511, 9'd0,   9'd256, 9'd400, 9'd401, 9'd402, 4'b0100, 10'd959},
    {10'd100, 10'd200, 9'd5,   9'd6,   9'd7,   9'd8,   9'd9,   9'd10,  4'b1000, 10'd0},
    {10'd17,  10'd512, 9'd1,   9'd2,   9'd3,   9'd4,   9'd5,   9'd6,   4'b1100, 10'd16},
    {10'd9,   10'd512, 9'd50,  9'd60,  9'd70,  9'd80,  9'd90,  9'd100, 4'b0010, 10'd8},
    {10'd700, 10'd300, 9'd123, 9'd234, 9'd345, 9'd456, 9'd12,  9'd34,  4'b0101, 10'd458},
    {10'd1023,10'd512, 9'd511, 9'd511, 9'd511, 9'd511, 9'd511, 9'd511, 4'b1011, 10'd959},
    {10'd1,   10'd512, 9'd2,   9'd4,   9'd8,   9'd16,  9'd32,  9'd64,  4'b1001, 10'd1},
    {10'd300, 10'd700, 9'd77,  9'd88,  9'd99,  9'd111, 9'd122, 9'd133, 4'b1100, 10'd458}
  };

  task automatic drive(input logic [87:0] v);
    {y_i, c_i, red_i, grn_i, blu_i, cr_i, yl_i, cb_i,
     svid_en_i, dmx_off_i, pd_lo_i, pd_hi_i} = v[87:10];
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // requirement-side model: which value each bus should show for a row
  function automatic int model(input int bus, input logic [87:0] v);
    int cv, cr9, r9;
    cv = int'(v[9:0]);
    if (v[11] && bus < 2) return 0;
    if (v[10] && bus >= 2) return 0;
    if (v[13]) begin
      if (bus == 0) return int'(v[87:78]);
      if (bus == 1) return int'(v[77:68]);
      return cv;
    end
    if (bus == 0) return cv;
    r9 = (bus == 1) ? int'(v[67:59]) : (bus == 2) ? int'(v[58:50]) : int'(v[49:41]);
    cr9 = (bus == 1) ? int'(v[40:32]) : (bus == 2) ? int'(v[31:23]) : int'(v[22:14]);
    return 2 * (v[12] ? cr9 : r9);
  endfunction

  function automatic string tag(input int bus, input logic [87:0] v);
    if ((v[11] && bus < 2) || (v[10] && bus >= 2)) return "R7";
    if (v[13]) return "R6";
    if (bus == 0) return "R3";
    if (v[12]) return "R5";
    return "R4";
  endfunction

  function automatic int bus_val(input int bus);
    case (bus)
      0: return int'(dac_cvbs_o);
      1: return int'(dac_red_o);
      2: return int'(dac_grn_o);
      default: return int'(dac_blu_o);
    endcase
  endfunction

  task automatic settle(input logic [87:0] v);
    @(negedge clk);
    drive(v);
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R8 actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: buses at zero during reset even with live inputs
    drive(TBL[5]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) chk("R1 reset", bus_val(k), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) chk("R1 after release", bus_val(k), 0);

    // table walked one row per cycle; R8 each row due three falling edges later
    for (int i = 0; i < N + 3; i++) begin
      @(negedge clk);
      if (i >= 3)
        for (int k = 0; k < 4; k++)
          chk(tag(k, TBL[i-3]), bus_val(k), model(k, TBL[i-3]));
      if (i < N) drive(TBL[i]);
      else       drive('0);
    end

    // R2: clamp at both ends
    settle({10'd0, 10'd0, 54'd0, 4'b0000, 10'd0});
    chk("R2 low clamp", int'(dac_cvbs_o), 0);
    settle({10'd1023, 10'd1023, 54'd0, 4'b0000, 10'd0});
    chk("R2 high clamp", int'(dac_cvbs_o), 959);
    settle({10'd512, 10'd0, 54'd0, 4'b0000, 10'd0});
    chk("R2 zero sum", int'(dac_cvbs_o), 0);

    // R7: power-down pairs are independent
    settle({10'd512, 10'd512, 9'd10, 9'd20, 9'd30, 27'd0, 4'b0010, 10'd0});
    chk("R7 lo pair", int'(dac_cvbs_o), 0);
    chk("R7 hi pair kept", int'(dac_grn_o), 40);
    settle({10'd512, 10'd512, 9'd10, 9'd20, 9'd30, 27'd0, 4'b0001, 10'd0});
    chk("R7 lo pair kept", int'(dac_red_o), 20);
    chk("R7 hi pair", int'(dac_blu_o), 0);

    // R8: exactly three edges from drive to bus
    settle({10'd0, 10'd0, 54'd0, 4'b0000, 10'd0});
    @(negedge clk);
    drive({10'd512, 10'd512, 9'd10, 45'd0, 4'b0000, 10'd0});
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8 not yet", int'(dac_cvbs_o), 0);
    @(negedge clk);
    chk("R8 arrived", int'(dac_cvbs_o), 480);
    chk("R8 red arrived", int'(dac_red_o), 20);

    // R1: reset clears the buses without a clock edge
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async clear", int'(dac_cvbs_o) + int'(dac_red_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    summary();
    $finish;
  end

endmodule